// File: doc/BRIEF.md
# Resident Block Admission Controller

This controller guards the resources of one compute unit and decides, one request at a time, whether an incoming thread block may become resident there. It keeps four independent pools: free registers, free shared-memory bytes, free warp slots and free block slots. A block states its thread count, registers per thread and shared-memory bytes. From these the controller derives the demand. The warp count is the thread count divided by the warp width and rounded up. The register demand is warps times warp width times registers per thread. The block is admitted only when every one of the four demands fits at the same moment.

An admitted block keeps its whole reservation until the last of its warps reports that it has finished. There is no partial release, no migration and no preemption. So whichever pool runs short first limits how many blocks can be resident. Requests are taken strictly in arrival order through a single port. A request that does not fit yet is held and blocks everything behind it. A request that could never fit, because it breaks a per-block limit or needs more than the unit's total capacity, is refused with a reject pulse instead of waiting forever.

The requester raises `req_valid` with the request fields and holds them until it sees either `req_accept` or `req_reject`. It then drops `req_valid` within one cycle. Each warp that finishes is reported as one pulse on `done_valid` together with the slot number the block was given.

Top module: `block_admit_ctrl`

## Requirements
- R1: After reset the status outputs show full capacity: 65536 registers, 233472 shared-memory bytes, 64 warp slots and 32 block slots. `req_accept` and `req_reject` are low.
- R2: Demand is computed from the request fields. Warps are ceil(threads/32) and registers are warps×32×registers-per-thread. A request that fits is accepted with a one-cycle `req_accept` in the cycle after the decision edge. From that same cycle each status output drops by the block's demand (one block slot). An exact fit that leaves zero is accepted.
- R3: If any one of the four pools is short, the request is not accepted. It stays pending with no ack, and no status output changes.
- R4: A request is refused with a one-cycle `req_reject` if any of these holds: threads is 0 or above 1024, registers per thread is 0 or above 255, shared memory is above 233472, or the register demand is above 65536. A refused request leaves every status output unchanged.
- R5: A finish pulse for a warp that is not the block's last leaves every status output unchanged.
- R6: When a finish pulse for a block's last warp is sampled at edge E, the block's whole reservation is added back on the status outputs after edge E+1 and not before.
- R7: A pending request is accepted without being re-sent once a release makes room for it.
- R8: No more than 32 blocks are resident. With all block slots held, a request that fits the other three pools still waits.
- R9: A finish pulse that names a slot holding no block has no effect on any status output or on any resident block.
- R10: An accepted block is given the lowest-numbered free slot, shown on `req_slot` while `req_accept` is high.
- R11: Each request gets exactly one ack pulse, accept or reject, never both. No decision is made in the cycle after an ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until acknowledged |
| req_threads | input | 11 | Threads in the block |
| req_rpt | input | 9 | Registers per thread |
| req_smem | input | 18 | Shared-memory bytes for the block |
| req_accept | output | 1 | One-cycle pulse: block admitted |
| req_reject | output | 1 | One-cycle pulse: request impossible |
| req_slot | output | 5 | Slot given to the admitted block |
| done_valid | input | 1 | One warp finished |
| done_slot | input | 5 | Slot of the block whose warp finished |
| free_regs | output | 17 | Registers not reserved |
| free_smem | output | 18 | Shared-memory bytes not reserved |
| free_warps | output | 7 | Warp slots not reserved |
| free_slots | output | 6 | Block slots not held |

## Verification
Three kinds of request are sent against a partly filled unit. In each, exactly one pool is too small: shared memory alone, registers alone while warps still fit, and warp slots alone. A design that tests only some of the four pools is therefore caught. A fourth pattern fills all 32 block slots with one-warp blocks. This separates the slot limit from the other pools and shows that a freed middle slot is reused first. The invalid requests probe each limit one past its edge, paired with an exact-fit request that must pass. The finish sequences separate the last warp from the earlier ones, pin the two-cycle release latency, and send pulses to empty slots to show that they are ignored.

// File: rtl/adm_pkg.sv
`timescale 1ns/1ps
package adm_pkg;
  // Ceiling division used for the warp count of a block.
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/adm_demand.sv
`timescale 1ns/1ps
// Turns the raw request fields into per-pool demand and flags requests that
// can never be satisfied.
module adm_demand import adm_pkg::*; #(
  parameter int unsigned WARP_SIZE   = 32,
  parameter int unsigned MAX_THREADS = 1024,
  parameter int unsigned MAX_RPT     = 255,
  parameter int unsigned NUM_REGS    = 65536,
  parameter int unsigned SMEM_BYTES  = 233472,
  parameter int unsigned NUM_WARPS   = 64,
  parameter int unsigned THR_W       = 11,
  parameter int unsigned RPT_W       = 9,
  parameter int unsigned SMEM_W      = 18
) (
  input  logic [THR_W-1:0]  threads_i,
  input  logic [RPT_W-1:0]  rpt_i,
  input  logic [SMEM_W-1:0] smem_i,
  output logic [31:0]       warps_o,
  output logic [31:0]       regs_o,
  output logic              bad_o
);
  logic thr_bad, rpt_bad, smem_bad, cap_bad;

  always_comb begin
    warps_o  = ceil_div(32'(threads_i), WARP_SIZE);
    regs_o   = warps_o * WARP_SIZE * 32'(rpt_i);
    thr_bad  = (threads_i == '0) || (32'(threads_i) > MAX_THREADS);
    rpt_bad  = (rpt_i == '0) || (32'(rpt_i) > MAX_RPT);
    smem_bad = 32'(smem_i) > SMEM_BYTES;
    cap_bad  = (regs_o > NUM_REGS) || (warps_o > NUM_WARPS);
    bad_o    = thr_bad || rpt_bad || smem_bad || cap_bad;
  end
endmodule

// File: rtl/adm_slot_alloc.sv
`timescale 1ns/1ps
// Occupancy bitmap of block slots with a lowest-free-first picker.
module adm_slot_alloc #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alloc_en,
  input  logic                 release_en,
  input  logic [SLOT_W-1:0]    release_idx,
  output logic                 has_free,
  output logic [SLOT_W-1:0]    free_idx,
  output logic [NUM_SLOTS-1:0] busy
);
  logic [NUM_SLOTS-1:0] busy_q;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        has_free = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      if (release_en) busy_q[release_idx] <= 1'b0;
      if (alloc_en)   busy_q[free_idx]    <= 1'b1;
    end
  end

  assign busy = busy_q;

  // R5: a retirement always frees a slot that was held
  assert_release_held_R5: assert property (@(posedge clk) disable iff (rst)
    release_en |-> busy_q[release_idx]);

  // R10: a new block never lands on a slot that is being retired in the same cycle
  assert_alloc_clash_R10: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && release_en) |-> (free_idx != release_idx));
endmodule

// File: rtl/adm_block_table.sv
`timescale 1ns/1ps
// Per-slot record of each resident block: warps still running and the
// reservation to hand back when the last one finishes.
module adm_block_table #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned WARP_CW   = 7,
  parameter int unsigned REG_CW    = 17,
  parameter int unsigned SMEM_W    = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_idx,
  input  logic [WARP_CW-1:0] wr_warps,
  input  logic [REG_CW-1:0]  wr_regs,
  input  logic [SMEM_W-1:0]  wr_smem,
  input  logic               done_valid,
  input  logic [SLOT_W-1:0]  done_idx,
  output logic               ret_valid,
  output logic [SLOT_W-1:0]  ret_idx,
  output logic [WARP_CW-1:0] ret_warps,
  output logic [REG_CW-1:0]  ret_regs,
  output logic [SMEM_W-1:0]  ret_smem
);
  logic [WARP_CW-1:0] rem_q   [NUM_SLOTS];
  logic [WARP_CW-1:0] warps_m [NUM_SLOTS];
  logic [REG_CW-1:0]  regs_m  [NUM_SLOTS];
  logic [SMEM_W-1:0]  smem_m  [NUM_SLOTS];

  logic hit, last;

  always_comb begin
    hit  = done_valid && (rem_q[done_idx] != '0);
    last = hit && (rem_q[done_idx] == WARP_CW'(1));
  end

  // Remaining-warp counters need a reset so that empty slots read as zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) rem_q[i] <= '0;
    end else begin
      if (hit)   rem_q[done_idx] <= rem_q[done_idx] - WARP_CW'(1);
      if (wr_en) rem_q[wr_idx]   <= wr_warps;
    end
  end

  // Reservation amounts: plain write port and registered read, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      warps_m[wr_idx] <= wr_warps;
      regs_m[wr_idx]  <= wr_regs;
      smem_m[wr_idx]  <= wr_smem;
    end
    ret_idx   <= done_idx;
    ret_warps <= warps_m[done_idx];
    ret_regs  <= regs_m[done_idx];
    ret_smem  <= smem_m[done_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) ret_valid <= 1'b0;
    else     ret_valid <= last;
  end

  // R8: admission only ever writes into an empty slot
  assert_write_empty_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (rem_q[wr_idx] == '0));

  // R9: admission and a counted finish never target the same slot
  assert_write_vs_done_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit) |-> (wr_idx != done_idx));

  // R6: a retirement always follows a sampled finish pulse
  assert_retire_cause_R6: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(done_valid));
endmodule

// File: rtl/block_admit_ctrl.sv
`timescale 1ns/1ps
// Admits thread blocks only when registers, shared memory, warp slots and a
// block slot all fit; holds the reservation until the block's last warp ends.
module block_admit_ctrl import adm_pkg::*; #(
  parameter int unsigned WARP_SIZE   = 32,
  parameter int unsigned MAX_THREADS = 1024,
  parameter int unsigned MAX_RPT     = 255,
  parameter int unsigned NUM_REGS    = 65536,
  parameter int unsigned SMEM_BYTES  = 233472,
  parameter int unsigned NUM_WARPS   = 64,
  parameter int unsigned NUM_SLOTS   = 32,
  parameter int unsigned THR_W       = $clog2(MAX_THREADS) + 1,
  parameter int unsigned RPT_W       = $clog2(MAX_RPT + 1) + 1,
  parameter int unsigned SMEM_W      = $clog2(SMEM_BYTES + 1),
  parameter int unsigned REG_CW      = $clog2(NUM_REGS + 1),
  parameter int unsigned WARP_CW     = $clog2(NUM_WARPS + 1),
  parameter int unsigned SLOT_W      = $clog2(NUM_SLOTS),
  parameter int unsigned SLOT_CW     = $clog2(NUM_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [THR_W-1:0]   req_threads,
  input  logic [RPT_W-1:0]   req_rpt,
  input  logic [SMEM_W-1:0]  req_smem,
  output logic               req_accept,
  output logic               req_reject,
  output logic [SLOT_W-1:0]  req_slot,
  input  logic               done_valid,
  input  logic [SLOT_W-1:0]  done_slot,
  output logic [REG_CW-1:0]  free_regs,
  output logic [SMEM_W-1:0]  free_smem,
  output logic [WARP_CW-1:0] free_warps,
  output logic [SLOT_CW-1:0] free_slots
);
  logic [31:0] dem_warps, dem_regs;
  logic        dem_bad;

  logic [REG_CW-1:0]  free_regs_q;
  logic [SMEM_W-1:0]  free_smem_q;
  logic [WARP_CW-1:0] free_warps_q;
  logic [SLOT_CW-1:0] free_slots_q;
  logic               accept_q, reject_q;
  logic [SLOT_W-1:0]  slot_q;

  logic                 slot_avail;
  logic [SLOT_W-1:0]    slot_pick;
  logic [NUM_SLOTS-1:0] slot_busy;

  logic               ret_valid;
  logic [SLOT_W-1:0]  ret_idx;
  logic [WARP_CW-1:0] ret_warps;
  logic [REG_CW-1:0]  ret_regs;
  logic [SMEM_W-1:0]  ret_smem;

  logic decide, fits, admit, refuse;
  logic [REG_CW-1:0]  take_regs, give_regs;
  logic [SMEM_W-1:0]  take_smem, give_smem;
  logic [WARP_CW-1:0] take_warps, give_warps;

  adm_demand #(
    .WARP_SIZE(WARP_SIZE), .MAX_THREADS(MAX_THREADS), .MAX_RPT(MAX_RPT),
    .NUM_REGS(NUM_REGS), .SMEM_BYTES(SMEM_BYTES), .NUM_WARPS(NUM_WARPS),
    .THR_W(THR_W), .RPT_W(RPT_W), .SMEM_W(SMEM_W)
  ) u_demand (
    .threads_i(req_threads), .rpt_i(req_rpt), .smem_i(req_smem),
    .warps_o(dem_warps), .regs_o(dem_regs), .bad_o(dem_bad)
  );

  adm_slot_alloc #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_slots (
    .clk(clk), .rst(rst),
    .alloc_en(admit), .release_en(ret_valid), .release_idx(ret_idx),
    .has_free(slot_avail), .free_idx(slot_pick), .busy(slot_busy)
  );

  adm_block_table #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .WARP_CW(WARP_CW),
    .REG_CW(REG_CW), .SMEM_W(SMEM_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(admit), .wr_idx(slot_pick), .wr_warps(take_warps),
    .wr_regs(take_regs), .wr_smem(take_smem),
    .done_valid(done_valid), .done_idx(done_slot),
    .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_warps(ret_warps),
    .ret_regs(ret_regs), .ret_smem(ret_smem)
  );

  // One decision per request; the cycle carrying an ack is skipped so the
  // requester has time to withdraw.
  always_comb begin
    decide = req_valid && !accept_q && !reject_q;
    fits   = (dem_regs <= 32'(free_regs_q)) &&
             (32'(req_smem) <= 32'(free_smem_q)) &&
             (dem_warps <= 32'(free_warps_q)) &&
             slot_avail;
    admit  = decide && !dem_bad && fits;
    refuse = decide && dem_bad;

    take_regs  = admit ? REG_CW'(dem_regs)   : '0;
    take_smem  = admit ? req_smem            : '0;
    take_warps = admit ? WARP_CW'(dem_warps) : '0;
    give_regs  = ret_valid ? ret_regs  : '0;
    give_smem  = ret_valid ? ret_smem  : '0;
    give_warps = ret_valid ? ret_warps : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_regs_q  <= REG_CW'(NUM_REGS);
      free_smem_q  <= SMEM_W'(SMEM_BYTES);
      free_warps_q <= WARP_CW'(NUM_WARPS);
      free_slots_q <= SLOT_CW'(NUM_SLOTS);
      accept_q     <= 1'b0;
      reject_q     <= 1'b0;
      slot_q       <= '0;
    end else begin
      free_regs_q  <= free_regs_q  - take_regs  + give_regs;
      free_smem_q  <= free_smem_q  - take_smem  + give_smem;
      free_warps_q <= free_warps_q - take_warps + give_warps;
      free_slots_q <= free_slots_q - SLOT_CW'(admit) + SLOT_CW'(ret_valid);
      accept_q     <= admit;
      reject_q     <= refuse;
      if (admit) slot_q <= slot_pick;
    end
  end

  assign req_accept = accept_q;
  assign req_reject = reject_q;
  assign req_slot   = slot_q;
  assign free_regs  = free_regs_q;
  assign free_smem  = free_smem_q;
  assign free_warps = free_warps_q;
  assign free_slots = free_slots_q;

  // R6: releases never push a pool above its capacity
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (free_regs_q <= REG_CW'(NUM_REGS)) && (free_smem_q <= SMEM_W'(SMEM_BYTES)) &&
    (free_warps_q <= WARP_CW'(NUM_WARPS)));

  // R8: block-slot count agrees with the allocator's bitmap
  assert_slot_count_R8: assert property (@(posedge clk) disable iff (rst)
    32'(free_slots_q) == NUM_SLOTS - 32'($countones(slot_busy)));

  // R11: never both acks, and no ack directly after an ack
  assert_single_ack_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({accept_q, reject_q}));
  assert_ack_gap_R11: assert property (@(posedge clk) disable iff (rst)
    (accept_q || reject_q) |=> !(accept_q || reject_q));

  // R3: a stalled request leaves every pool untouched
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (decide && !dem_bad && !fits && !ret_valid) |=>
      ($stable(free_regs_q) && $stable(free_smem_q) && $stable(free_warps_q)));

  // R4: a refused request leaves every pool untouched
  assert_reject_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (refuse && !ret_valid) |=>
      ($stable(free_regs_q) && $stable(free_smem_q) && $stable(free_slots_q)));
endmodule

// File: tb/block_admit_ctrl_tb.sv
`timescale 1ns/1ps
module block_admit_ctrl_tb;
  localparam int NSLOT = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [10:0] req_threads = '0;
  logic [8:0]  req_rpt = '0;
  logic [17:0] req_smem = '0;
  logic        req_accept, req_reject;
  logic [4:0]  req_slot;
  logic        done_valid = 1'b0;
  logic [4:0]  done_slot = '0;
  logic [16:0] free_regs;
  logic [17:0] free_smem;
  logic [6:0]  free_warps;
  logic [5:0]  free_slots;

  always #5 clk = ~clk;

  block_admit_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_threads(req_threads),
    .req_rpt(req_rpt), .req_smem(req_smem), .req_accept(req_accept),
    .req_reject(req_reject), .req_slot(req_slot), .done_valid(done_valid),
    .done_slot(done_slot), .free_regs(free_regs), .free_smem(free_smem),
    .free_warps(free_warps), .free_slots(free_slots)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // Reference model of the four pools and per-slot reservations.
  int m_regs = 65536, m_smem = 233472, m_warps = 64, m_slots = NSLOT;
  int b_regs[NSLOT], b_smem[NSLOT], b_warps[NSLOT], b_rem[NSLOT];

  task automatic chk_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_status(input string tag);
    chk_eq(tag, "free_regs",  int'(free_regs),  m_regs);
    chk_eq(tag, "free_smem",  int'(free_smem),  m_smem);
    chk_eq(tag, "free_warps", int'(free_warps), m_warps);
    chk_eq(tag, "free_slots", int'(free_slots), m_slots);
  endtask

  task automatic note_admit(input int thr, input int rpt, input int sm, input int slot);
    int w;
    w = (thr + 31) / 32;
    b_warps[slot] = w; b_rem[slot] = w;
    b_regs[slot] = w * 32 * rpt; b_smem[slot] = sm;
    m_regs -= b_regs[slot]; m_smem -= sm; m_warps -= w; m_slots -= 1;
  endtask

  task automatic note_done(input int slot);
    if (b_rem[slot] > 0) begin
      b_rem[slot]--;
      if (b_rem[slot] == 0) begin
        m_regs += b_regs[slot]; m_smem += b_smem[slot];
        m_warps += b_warps[slot]; m_slots += 1;
      end
    end
  endtask

  // Wait for the ack of the request currently driven; 0 = none yet (still held).
  task automatic wait_ack(input int thr, input int rpt, input int sm, input int wait_max,
                          output int res, output int slot);
    res = 0; slot = -1;
    for (int i = 0; i < wait_max; i++) begin
      @(negedge clk);
      if (req_accept) begin res = 1; slot = int'(req_slot); break; end
      if (req_reject) begin res = 2; break; end
    end
    if (res != 0) begin
      if (res == 1) note_admit(thr, rpt, sm, slot);
      req_valid = 1'b0;
      @(negedge clk);
      chk_eq("R11", "ack pulse after withdraw", int'(req_accept) + int'(req_reject), 0);
    end
  endtask

  task automatic send(input int thr, input int rpt, input int sm, input int wait_max,
                      output int res, output int slot);
    req_threads = 11'(thr); req_rpt = 9'(rpt); req_smem = 18'(sm);
    req_valid = 1'b1;
    wait_ack(thr, rpt, sm, wait_max, res, slot);
  endtask

  task automatic finish(input int slot, input int count, input int idle);
    for (int i = 0; i < count; i++) begin
      done_valid = 1'b1; done_slot = 5'(slot);
      @(negedge clk);
      note_done(slot);
      done_valid = 1'b0;
    end
    repeat (idle) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_status("R1");
    chk_eq("R1", "ack after reset", int'(req_accept) + int'(req_reject), 0);
  endtask

  task automatic t_basic;
    int res, slot;
    send(100, 40, 1000, 4, res, slot);          // 4 warps, 5120 regs
    chk_eq("R2", "accept 100x40", res, 1);
    chk_eq("R10", "first slot", slot, 0);
    chk_status("R2");
    send(96, 10, 0, 4, res, slot);              // 3 warps, 960 regs
    chk_eq("R2", "accept 96x10", res, 1);
    chk_eq("R10", "second slot", slot, 1);
    chk_status("R2");
    finish(0, 3, 2);
    chk_status("R5");
    done_valid = 1'b1; done_slot = 5'd0;
    @(negedge clk);
    done_valid = 1'b0;
    chk_status("R6");                           // not yet released
    @(negedge clk);
    note_done(0);
    chk_status("R6");                           // released now
    finish(1, 3, 2);
    chk_status("R5");
  endtask

  task automatic t_reject;
    int res, slot;
    int thr[6] = '{0, 1025, 32, 32, 32, 1024};
    int rpt[6] = '{8, 8, 0, 256, 8, 65};
    int sm[6]  = '{0, 0, 0, 0, 233473, 0};
    for (int k = 0; k < 6; k++) begin
      send(thr[k], rpt[k], sm[k], 4, res, slot);
      chk_eq("R4", "reject case", res, 2);
      chk_status("R4");
    end
    send(1024, 64, 233472, 4, res, slot);       // exact fit of regs and smem
    chk_eq("R2", "exact fit accept", res, 1);
    chk_status("R2");
    finish(slot, 32, 2);
    chk_status("R6");
  endtask

  task automatic t_short(input string what, input int a_thr, input int a_rpt, input int a_sm,
                         input int b_thr, input int b_rpt, input int b_sm,
                         input int c_thr, input int c_rpt, input int c_sm);
    int res, sa, sb, sc;
    send(a_thr, a_rpt, a_sm, 4, res, sa);
    chk_eq("R2", {what, " holder A"}, res, 1);
    sb = -1;
    if (b_thr > 0) begin
      send(b_thr, b_rpt, b_sm, 4, res, sb);
      chk_eq("R2", {what, " holder B"}, res, 1);
    end
    send(c_thr, c_rpt, c_sm, 6, res, sc);
    chk_eq("R3", {what, " pending"}, res, 0);
    chk_status("R3");
    finish(sa, b_warps[sa], 0);
    wait_ack(c_thr, c_rpt, c_sm, 6, res, sc);
    chk_eq("R7", {what, " admitted after release"}, res, 1);
    chk_status("R7");
    if (sb >= 0) finish(sb, b_warps[sb], 0);
    finish(sc, b_warps[sc], 2);
    chk_status("R6");
  endtask

  task automatic t_slots;
    int res, slot;
    for (int i = 0; i < NSLOT; i++) begin
      send(32, 1, 0, 4, res, slot);
      chk_eq("R10", "ascending slot", slot, i);
    end
    chk_status("R8");
    send(32, 1, 0, 6, res, slot);
    chk_eq("R8", "33rd block pending", res, 0);
    finish(5, 1, 0);
    wait_ack(32, 1, 0, 6, res, slot);
    chk_eq("R8", "33rd block admitted", res, 1);
    chk_eq("R10", "reused middle slot", slot, 5);
    for (int i = 0; i < NSLOT; i++) finish(i, 1, 0);
    repeat (2) @(negedge clk);
    chk_status("R8");
  endtask

  task automatic t_ignore;
    int res, slot;
    send(64, 8, 500, 4, res, slot);             // 2 warps in slot 0
    chk_eq("R9", "holder admitted", slot, 0);
    finish(7, 2, 2);
    chk_status("R9");
    finish(0, 1, 2);
    chk_status("R5");
    finish(0, 1, 2);
    chk_status("R9");
  endtask

  initial begin
    for (int i = 0; i < NSLOT; i++) begin
      b_regs[i] = 0; b_smem[i] = 0; b_warps[i] = 0; b_rem[i] = 0;
    end
    t_reset();
    t_basic();
    t_reject();
    t_short("smem",  1, 1, 200000, 0, 0, 0, 1, 1, 40000);
    t_short("regs",  1024, 40, 0, 0, 0, 0, 1024, 30, 0);
    t_short("warps", 1024, 1, 0, 1024, 1, 0, 32, 1, 0);
    t_slots();
    t_ignore();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule